// File: doc/BRIEF.md
# Boosted Cascade Stage Evaluator

This block runs one stage of a boosted detection cascade over candidate sub-windows. An upstream queue presents the base address of each sub-window. The block then walks a fixed list of weak classifiers, one after another. For each classifier it fetches corner words from an integral-image memory through one random-access read port and reduces them to rectangle sums. It weights and combines those sums into a feature value and compares that value with the classifier's threshold to pick one of two votes. The votes add into a stage sum.

When the last classifier has voted, the stage sum is compared with the stage threshold. A passing window's base address goes to the next stage through an output handshake. A failing window is dropped and leaves no trace. The classifier parameters are held in an internal table computed at elaboration. A done pulse marks the point where the upstream side has signalled end of image and no window is left in flight.

The engine is memory-bound by design. It issues one read per cycle and evaluates one window at a time, so the block that follows sees only the survivors.

Top module: `cascade_stage_eval`

## Requirements
- R1: While reset is held, `in_ready` is 1 and `out_valid`, `rd_en` and `done` are 0.
- R2: After a window with base B is accepted, the block issues 8·NWC reads on consecutive cycles with `rd_en` high. Read i belongs to classifier k = i/8, rectangle r = (i mod 8)/4 and corner c = i mod 4. The rectangle's top-left word is t = B + k + 2r, and its height is h = 2 + k words. Corners c = 0, 1, 2, 3 sit at t, t+2, t+h·IMG_W and t+h·IMG_W+2.
- R3: `rd_data` is taken in the cycle after the cycle in which its address was presented with `rd_en` high.
- R4: A rectangle sum is word(c=3) − word(c=1) − word(c=2) + word(c=0), in signed 32-bit arithmetic. A classifier's feature is its rectangle-0 sum times weight +1 plus its rectangle-1 sum times weight −1.
- R5: Classifier k votes −3 when its feature is strictly below 4k − 4, and k + 2 otherwise. The stage sum is the total of all votes.
- R6: A window passes when its stage sum is greater than or equal to SUM_THR (default 2), including the case of exact equality. Only the addresses of passing windows appear on `out_addr`, in acceptance order. Failing windows produce no output.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_addr` holds. `in_ready` is low from acceptance until the window is dropped or its address is taken.
- R8: A one-cycle `in_eoi` pulse leads to exactly one one-cycle `done` pulse. That pulse comes after every window accepted before it has been decided and, if passing, handed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Candidate address valid |
| in_ready | output | 1 | Block can accept a candidate |
| in_addr | input | AW | Sub-window base address |
| in_eoi | input | 1 | End-of-image pulse from the upstream queue |
| rd_en | output | 1 | Integral-image read request |
| rd_addr | output | AW | Integral-image word address |
| rd_data | input | 32 | Integral-image word, one cycle after the request |
| out_valid | output | 1 | Passing address valid |
| out_ready | input | 1 | Downstream accepts the address |
| out_addr | output | AW | Address of a passing window |
| done | output | 1 | One-cycle pulse: image finished |

## Verification
The assertions assume that the upstream side pulses `in_eoi` only after its last candidate has been accepted. They also assume that the read port answers every request in the following cycle with no gaps. The stimulus keeps to both assumptions: the bench memory model always answers on the next edge, and the end-of-image pulse is raised only after the final send has completed its handshake. Window bases are drawn so that every corner read stays inside the modelled memory. `out_ready` is toggled at random so that the output is held back at varying points.

// File: rtl/cse_pkg.sv
package cse_pkg;
  localparam int PW = 24;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT, S_EMIT} seq_state_t;

  // 13 parameters per weak classifier, 24 bits each
  typedef struct packed {
    logic [7:0][PW-1:0] corner_off;
    logic [1:0][PW-1:0] weight;
    logic [PW-1:0]      thr;
    logic [PW-1:0]      vote_lo;
    logic [PW-1:0]      vote_hi;
  } wc_param_t;

  function automatic wc_param_t wc_entry(input int k, input int img_w);
    wc_param_t p;
    int tl;
    for (int r = 0; r < 2; r++) begin
      tl = k + 2 * r;
      p.corner_off[4*r+0] = PW'(tl);
      p.corner_off[4*r+1] = PW'(tl + 2);
      p.corner_off[4*r+2] = PW'(tl + (2 + k) * img_w);
      p.corner_off[4*r+3] = PW'(tl + (2 + k) * img_w + 2);
    end
    p.weight[0] = PW'(1);
    p.weight[1] = PW'(-1);
    p.thr       = PW'(4 * k - 4);
    p.vote_lo   = PW'(-3);
    p.vote_hi   = PW'(k + 2);
    return p;
  endfunction

  function automatic logic signed [31:0] sext(input logic [PW-1:0] v);
    return {{(32-PW){v[PW-1]}}, v};
  endfunction

  // corners 1 and 2 subtract, corners 0 and 3 add
  function automatic logic signed [31:0] corner_term(input logic [1:0] c,
                                                      input logic signed [31:0] d);
    return (c == 2'd1 || c == 2'd2) ? -d : d;
  endfunction

  function automatic logic signed [31:0] weigh(input logic [PW-1:0] w,
                                                input logic signed [31:0] t);
    return sext(w) * t;
  endfunction

  function automatic logic signed [31:0] pick_vote(input logic signed [31:0] f,
                                                    input logic [PW-1:0] thr,
                                                    input logic [PW-1:0] lo,
                                                    input logic [PW-1:0] hi);
    return (f < sext(thr)) ? sext(lo) : sext(hi);
  endfunction
endpackage

// File: rtl/cse_param_rom.sv
module cse_param_rom
  import cse_pkg::*;
#(
  parameter int NWC   = 3,
  parameter int IMG_W = 32,
  parameter int IW    = 5
) (
  input  logic [IW-1:0] idx_a,
  input  logic [IW-1:0] idx_b,
  output logic [PW-1:0] off_a,
  output logic [PW-1:0] weight_b,
  output logic [PW-1:0] thr_b,
  output logic [PW-1:0] lo_b,
  output logic [PW-1:0] hi_b
);
  wc_param_t tbl [NWC];

  for (genvar g = 0; g < NWC; g++) begin : g_entry
    assign tbl[g] = wc_entry(g, IMG_W);
  end

  wc_param_t ent_a, ent_b;
  assign ent_a    = tbl[idx_a[IW-1:3]];
  assign ent_b    = tbl[idx_b[IW-1:3]];
  assign off_a    = ent_a.corner_off[idx_a[2:0]];
  assign weight_b = ent_b.weight[idx_b[2]];
  assign thr_b    = ent_b.thr;
  assign lo_b     = ent_b.vote_lo;
  assign hi_b     = ent_b.vote_hi;
endmodule

// File: rtl/cse_seq.sv
module cse_seq
  import cse_pkg::*;
#(
  parameter int AW    = 12,
  parameter int NREAD = 24,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic          in_eoi,
  input  logic          out_ready,
  input  logic          verdict_valid,
  input  logic          verdict_pass,
  input  logic [PW-1:0] corner_off,
  output logic          in_ready,
  output logic          start,
  output logic          rd_en,
  output logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic          done
);
  seq_state_t    state;
  logic [AW-1:0] base;
  logic [IW-1:0] idx;
  logic          eoi_pend;

  assign in_ready  = (state == S_IDLE);
  assign start     = in_valid && in_ready;
  assign rd_en     = (state == S_RUN);
  assign rd_idx    = idx;
  assign rd_addr   = base + corner_off[AW-1:0];
  assign out_valid = (state == S_EMIT);
  assign out_addr  = base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      base     <= '0;
      idx      <= '0;
      eoi_pend <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (in_eoi) eoi_pend <= 1'b1;
      case (state)
        S_IDLE: begin
          if (in_valid) begin
            base  <= in_addr;
            idx   <= '0;
            state <= S_RUN;
          end else if (eoi_pend) begin
            done     <= 1'b1;
            eoi_pend <= in_eoi;
          end
        end
        S_RUN: begin
          idx <= idx + 1'b1;
          if (idx == IW'(NREAD - 1)) state <= S_WAIT;
        end
        S_WAIT: if (verdict_valid) state <= verdict_pass ? S_EMIT : S_IDLE;
        S_EMIT: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cse_accum.sv
module cse_accum
  import cse_pkg::*;
#(
  parameter int NREAD   = 24,
  parameter int IW      = 5,
  parameter int SUM_THR = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  input  logic [31:0]   rd_data,
  input  logic [PW-1:0] weight,
  input  logic [PW-1:0] thr,
  input  logic [PW-1:0] vote_lo,
  input  logic [PW-1:0] vote_hi,
  output logic [IW-1:0] eval_idx,
  output logic          vote_fire,
  output logic          verdict_valid,
  output logic          verdict_pass
);
  localparam logic signed [31:0] THR_S = 32'(SUM_THR);

  logic                vld_d;
  logic [IW-1:0]       idx_d;
  logic signed [31:0]  feat, sum;
  logic signed [31:0]  fnext, sum_next;
  logic                last;

  assign eval_idx  = idx_d;
  assign fnext     = feat + weigh(weight, corner_term(idx_d[1:0], $signed(rd_data)));
  assign sum_next  = sum + pick_vote(fnext, thr, vote_lo, vote_hi);
  assign vote_fire = vld_d && (idx_d[2:0] == 3'd7);
  assign last      = (idx_d == IW'(NREAD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_d         <= 1'b0;
      idx_d         <= '0;
      feat          <= '0;
      sum           <= '0;
      verdict_valid <= 1'b0;
      verdict_pass  <= 1'b0;
    end else begin
      vld_d         <= rd_en;
      idx_d         <= rd_idx;
      verdict_valid <= 1'b0;
      if (start) begin
        feat <= '0;
        sum  <= '0;
      end else if (vld_d) begin
        if (vote_fire) begin
          feat <= '0;
          sum  <= sum_next;
          if (last) begin
            verdict_valid <= 1'b1;
            verdict_pass  <= (sum_next >= THR_S);
          end
        end else begin
          feat <= fnext;
        end
      end
    end
  end
endmodule

// File: rtl/cascade_stage_eval.sv
module cascade_stage_eval
  import cse_pkg::*;
#(
  parameter int AW      = 12,
  parameter int IMG_W   = 32,
  parameter int NWC     = 3,
  parameter int SUM_THR = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic          in_eoi,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          done
);
  localparam int NREAD = NWC * 8;
  localparam int IW    = $clog2(NREAD);

  logic          start;
  logic [IW-1:0] rd_idx, eval_idx;
  logic [PW-1:0] off_a, weight_b, thr_b, lo_b, hi_b;
  // named events for the checker
  logic          vote_fire, verdict_valid, verdict_pass;

  cse_param_rom #(.NWC(NWC), .IMG_W(IMG_W), .IW(IW)) u_rom (
    .idx_a(rd_idx), .idx_b(eval_idx), .off_a(off_a),
    .weight_b(weight_b), .thr_b(thr_b), .lo_b(lo_b), .hi_b(hi_b)
  );

  cse_seq #(.AW(AW), .NREAD(NREAD), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_eoi(in_eoi), .out_ready(out_ready), .verdict_valid(verdict_valid),
    .verdict_pass(verdict_pass), .corner_off(off_a), .in_ready(in_ready),
    .start(start), .rd_en(rd_en), .rd_idx(rd_idx), .rd_addr(rd_addr),
    .out_valid(out_valid), .out_addr(out_addr), .done(done)
  );

  cse_accum #(.NREAD(NREAD), .IW(IW), .SUM_THR(SUM_THR)) u_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_data(rd_data), .weight(weight_b), .thr(thr_b), .vote_lo(lo_b),
    .vote_hi(hi_b), .eval_idx(eval_idx), .vote_fire(vote_fire),
    .verdict_valid(verdict_valid), .verdict_pass(verdict_pass)
  );
endmodule

// File: rtl/cse_checker.sv
module cse_checker #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          rd_en,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic          done,
  input logic          vote_fire,
  input logic          verdict_valid,
  input logic          verdict_pass
);
  assert_emit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr));

  assert_one_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && (out_valid || rd_en)));

  assert_vote_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vote_fire |-> !in_ready);

  assert_emit_after_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(verdict_valid && verdict_pass));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready && !rd_en && !out_valid);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind cascade_stage_eval cse_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .rd_en(rd_en),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .done(done), .vote_fire(vote_fire), .verdict_valid(verdict_valid),
  .verdict_pass(verdict_pass)
);

// File: tb/cascade_stage_eval_bench.sv
module cascade_stage_eval_bench;
  localparam int AW = 12, IMG_W = 32, NWC = 3, SUM_THR = 2, MEMSZ = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_eoi = 1'b0, out_ready = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [31:0] rd_data = '0;
  logic in_ready, rd_en, out_valid, done;
  logic [AW-1:0] rd_addr, out_addr;

  always #10 clk = ~clk;

  cascade_stage_eval #(.AW(AW), .IMG_W(IMG_W), .NWC(NWC), .SUM_THR(SUM_THR)) u_cascade_stage_eval (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_eoi(in_eoi), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .done(done)
  );

  int img [MEMSZ];
  int n_checks = 0, n_err = 0, n_pass = 0, n_out = 0;
  int cur_base = 0, rd_cnt = 0;
  int exp_q [$];
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int corner_addr(input int b, input int i);
    int k, r, c, tl;
    k = i / 8; r = (i % 8) / 4; c = i % 4;
    tl = b + k + 2 * r;
    return tl + ((c >= 2) ? (2 + k) * IMG_W : 0) + ((c % 2 == 1) ? 2 : 0);
  endfunction

  function automatic bit window_passes(input int b);
    int s, f, total;
    total = 0;
    for (int k = 0; k < NWC; k++) begin
      f = 0;
      for (int r = 0; r < 2; r++) begin
        s = img[corner_addr(b, 8*k+4*r+3)] - img[corner_addr(b, 8*k+4*r+1)]
          - img[corner_addr(b, 8*k+4*r+2)] + img[corner_addr(b, 8*k+4*r)];
        f = (r == 0) ? f + s : f - s;
      end
      total += (f < 4 * k - 4) ? -3 : k + 2;
    end
    return total >= SUM_THR;
  endfunction

  // memory model: answers in the cycle after the request (R3)
  always @(posedge clk) if (rd_en) rd_data <= img[rd_addr];

  // read address order (R2)
  initial forever begin
    @(negedge clk);
    if (rst_n && rd_en) begin
      check(int'(rd_addr) == corner_addr(cur_base, rd_cnt) && !in_ready, "R2",
            int'(rd_addr), corner_addr(cur_base, rd_cnt));
      rd_cnt++;
    end
  end

  // output side: random backpressure, hold and order checks
  initial begin
    bit hold_prev = 0;
    int hold_addr = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        out_ready = ($urandom_range(0, 3) != 0);
        if (hold_prev) check(out_valid && int'(out_addr) == hold_addr, "R7", int'(out_addr), hold_addr);
        hold_prev = out_valid && !out_ready;
        hold_addr = int'(out_addr);
        if (out_valid && out_ready) begin
          n_out++;
          if (exp_q.size() == 0) check(1'b0, "R6", int'(out_addr), -1);
          else check(int'(out_addr) == exp_q[0], "R3,R4,R5,R6", int'(out_addr), exp_q[0]);
          if (exp_q.size() != 0) void'(exp_q.pop_front());
        end
      end
    end
  end

  task automatic send(input int b);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = AW'(b);
    while (!in_ready) @(negedge clk);
    cur_base = b;
    rd_cnt   = 0;
    if (window_passes(b)) begin
      exp_q.push_back(b);
      n_pass++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_image(input bit expect_empty);
    int t = 0;
    bit seen = 0;
    @(negedge clk); in_eoi = 1'b1;
    @(negedge clk); in_eoi = 1'b0;
    while (t < 300 && !seen) begin
      if (done) seen = 1;
      else begin @(negedge clk); t++; end
    end
    check(seen, "R8", seen, 1);
    if (expect_empty) check(exp_q.size() == 0 && !out_valid, "R8", exp_q.size(), 0);
    @(negedge clk);
    check(!done, "R8", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < MEMSZ; i++) img[i] = $urandom_range(0, 63);
    for (int i = 3720; i < 3990; i++) img[i] = 0;
    img[3850 + 2*IMG_W + 2] = -10;   // drives classifier 0 to its low vote

    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", in_ready, 1);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(rd_en == 1'b0, "R1", rd_en, 0);
    check(done == 1'b0, "R1", done, 0);
    rst_n = 1'b1;

    finish_image(1'b1);               // end of image with nothing in flight (R8)

    send(3720);                       // all-zero window: sum equals SUM_THR, passes (R6)
    send(3850);                       // stage sum -3, dropped (R5, R6)
    for (int w = 0; w < 60; w++) begin
      send($urandom_range(0, 3700));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    finish_image(1'b1);               // done only after the last window is out (R8)

    check(n_out == n_pass, "R6", n_out, n_pass);
    check(n_pass > 0 && n_pass < 62, "R6", n_pass, 31);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule